// File: doc/BRIEF.md
# Nested Loop Address Sequencer

This block drives the operand and result pointers of a streaming arithmetic unit. It runs a nest of five loop counters. Loop 0 is the innermost and loop 4 is the outermost. Each accepted cycle is one iteration of the innermost loop, and a carry ripples outward whenever a loop passes its last value. Three independent pointer units follow the nest. On every iteration step, each unit adds one entry of its own signed step table to its pointer. The entry is picked by the outermost loop that moves on that step.

Software programs the setup before it pulses `start_i`: the loop limits and enables, the number of loops in use, the step tables, the base pointers, and two nesting levels. One level marks the iterations where the accumulator is cleared. The other marks the iterations where a result is written out. While the nest runs, the block exposes the loop indices, the three pointers and the two strobes. `stall_i` lets a downstream memory conflict hold everything in place. A single-cycle `done_o` closes each run.

Top module: `loop_addr_gen`

## Requirements
- R1: After reset the block is idle. `busy_o`, `done_o`, `init_o` and `store_o` are 0, and all indices and pointers are 0.
- R2: A `start_i` pulse while idle clears every index and loads each pointer from its base. `busy_o` is 1 from the next cycle. A `start_i` pulse while busy has no effect on the indices or the pointers.
- R3: Each iteration that is not stalled raises loop 0 by one. A loop that stands at its limit returns to 0 and raises the next outer loop by one. Loop k sits in `idx_o[16k +: 16]`.
- R4: A loop is active when its enable bit is 1 and its number is at most `outer_lvl_i`. An inactive loop stays at index 0 and acts as if its limit were 0, so it never holds back the carry.
- R5: On each accepted iteration that is not the last, pointer a grows by its step table entry `step_i[(a*5+k)*32 +: 32]`. Here k is the highest loop number that receives a carry on that step. The entry is signed two's complement, and the sum wraps modulo 2^32.
- R6: A cycle with `stall_i` high while busy leaves the indices, the pointers and `busy_o` unchanged.
- R7: A run holds exactly the product of (limit+1) over the active loops in iterations. `done_o` is 1 for exactly one cycle, the cycle after the last iteration is accepted, and `busy_o` is 0 from that cycle on.
- R8: `init_o` is high on an iteration when every loop numbered below `init_lvl_i` is at index 0. When `init_lvl_i` is 0, `init_o` is high on every iteration.
- R9: `store_o` is high on an iteration when every loop numbered below `store_lvl_i` is at its effective limit.
- R10: The three pointer units use separate step tables and separate bases, so each pointer follows its own arithmetic sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run (only acted on when idle) |
| stall_i | input | 1 | Freeze the nest and pointers this cycle |
| loop_en_i | input | 5 | Enable bit per loop |
| loop_max_i | input | 80 | Limit of loop k at bits [16k +: 16] |
| outer_lvl_i | input | 3 | Highest loop number in use |
| init_lvl_i | input | 3 | Nesting level of accumulator clear |
| store_lvl_i | input | 3 | Nesting level of result write |
| base_i | input | 96 | Base of pointer a at bits [32a +: 32] |
| step_i | input | 480 | Signed step of pointer a, level k at bits [(5a+k)*32 +: 32] |
| busy_o | output | 1 | An iteration is presented this cycle |
| idx_o | output | 80 | Current loop indices |
| addr_o | output | 96 | Current pointers |
| init_o | output | 1 | Clear accumulator on this iteration |
| store_o | output | 1 | Write result on this iteration |
| done_o | output | 1 | One-cycle end-of-run pulse |

## Verification
Indices, pointers and strobes belong to the iteration presented in the current cycle. They are due one edge after `start_i` for iteration 0, and one edge after each unstalled cycle for every later iteration. `done_o` is due exactly one edge after the final accepted iteration. The bench samples on the falling edge. It keeps an iteration number that advances only past an unstalled rising edge. From that number and the programmed loop sizes it derives, by division and modulo, the indices, the count of carries into each level (and so each pointer's sum), and both strobes.

// File: rtl/lag_pkg.sv
package lag_pkg;
  localparam int NUM_LOOPS = 5;
  localparam int CNT_W     = 16;
  localparam int NUM_AGU   = 3;
  localparam int ADDR_W    = 32;
endpackage

// File: rtl/lag_loop_nest.sv
module lag_loop_nest #(
  parameter int NL = 5,
  parameter int CW = 16,
  parameter int LW = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           stall_i,
  input  logic [NL-1:0]  en_i,
  input  logic [NL*CW-1:0] max_i,
  input  logic [LW-1:0]  outer_lvl_i,
  input  logic [LW-1:0]  init_lvl_i,
  input  logic [LW-1:0]  store_lvl_i,
  output logic [NL*CW-1:0] cnt_o,
  output logic           busy_o,
  output logic           load_o,
  output logic           step_o,
  output logic [LW-1:0]  lvl_o,
  output logic           init_o,
  output logic           store_o,
  output logic           done_o
);
  logic [CW-1:0] cnt_q [NL];
  logic [CW-1:0] eff_max [NL];
  logic [NL-1:0] act, wrap;
  logic [NL:0]   carry;
  logic          busy_q, done_q, adv, last;
  logic          init_all, store_all;

  assign carry[0] = 1'b1;

  for (genvar k = 0; k < NL; k++) begin : g_loop
    assign act[k]       = en_i[k] && (LW'(k) <= outer_lvl_i);
    assign eff_max[k]   = act[k] ? max_i[k*CW +: CW] : '0;
    assign wrap[k]      = (cnt_q[k] == eff_max[k]);
    assign carry[k+1]   = carry[k] & wrap[k];
    assign cnt_o[k*CW +: CW] = cnt_q[k];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                cnt_q[k] <= '0;
      else if (load_o)            cnt_q[k] <= '0;
      else if (adv && carry[k])   cnt_q[k] <= wrap[k] ? '0 : cnt_q[k] + 1'b1;
    end

    AST_IDLE_LOOP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_q && !act[k] && !load_o |=> cnt_q[k] == '0); // R4
  end

  assign last   = carry[NL];
  assign load_o = start_i & ~busy_q;
  assign adv    = busy_q & ~stall_i;
  assign step_o = adv & ~last;

  // outermost level receiving a carry this step
  always_comb begin
    lvl_o = '0;
    for (int k = 0; k < NL; k++)
      if (carry[k]) lvl_o = LW'(k);
  end

  always_comb begin
    init_all  = 1'b1;
    store_all = 1'b1;
    for (int k = 0; k < NL; k++) begin
      if (LW'(k) < init_lvl_i && cnt_q[k] != '0) init_all = 1'b0;
      if (LW'(k) < store_lvl_i && !wrap[k])      store_all = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= adv & last;
      if (load_o)          busy_q <= 1'b1;
      else if (adv & last) busy_q <= 1'b0;
    end
  end

  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign init_o  = busy_q & init_all;
  assign store_o = busy_q & store_all;

  AST_START_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> busy_q && cnt_o == '0); // R2
  AST_STALL_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && stall_i |=> busy_q && $stable(cnt_o)); // R6
  AST_INNER_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv && act[0] && cnt_q[0] < max_i[CW-1:0] |=> cnt_q[0] == $past(cnt_q[0]) + 1'b1); // R3
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R7
endmodule

// File: rtl/lag_agu.sv
module lag_agu #(
  parameter int AW = 32,
  parameter int NL = 5,
  parameter int LW = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            step_i,
  input  logic [LW-1:0]   lvl_i,
  input  logic [AW-1:0]   base_i,
  input  logic [NL*AW-1:0] tbl_i,
  output logic [AW-1:0]   addr_o
);
  logic [AW-1:0] addr_q, inc;

  always_comb begin
    inc = '0;
    for (int k = 0; k < NL; k++)
      if (LW'(k) == lvl_i) inc = tbl_i[k*AW +: AW];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      addr_q <= '0;
    else if (load_i)  addr_q <= base_i;
    else if (step_i)  addr_q <= addr_q + inc;
  end

  assign addr_o = addr_q;

  AST_BASE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> addr_q == $past(base_i)); // R2
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && !step_i |=> $stable(addr_q)); // R6
endmodule

// File: rtl/loop_addr_gen.sv
module loop_addr_gen
  import lag_pkg::*;
#(
  parameter int N_LOOP = NUM_LOOPS,
  parameter int IDX_W  = CNT_W,
  parameter int N_PTR  = NUM_AGU,
  parameter int PTR_W  = ADDR_W,
  localparam int LVL_W = $clog2(N_LOOP + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     stall_i,
  input  logic [N_LOOP-1:0]        loop_en_i,
  input  logic [N_LOOP*IDX_W-1:0]  loop_max_i,
  input  logic [LVL_W-1:0]         outer_lvl_i,
  input  logic [LVL_W-1:0]         init_lvl_i,
  input  logic [LVL_W-1:0]         store_lvl_i,
  input  logic [N_PTR*PTR_W-1:0]   base_i,
  input  logic [N_PTR*N_LOOP*PTR_W-1:0] step_i,
  output logic                     busy_o,
  output logic [N_LOOP*IDX_W-1:0]  idx_o,
  output logic [N_PTR*PTR_W-1:0]   addr_o,
  output logic                     init_o,
  output logic                     store_o,
  output logic                     done_o
);
  logic             load, step;
  logic [LVL_W-1:0] lvl;

  lag_loop_nest #(.NL(N_LOOP), .CW(IDX_W), .LW(LVL_W)) u_nest (
    .clk_i, .rst_ni, .start_i, .stall_i,
    .en_i(loop_en_i), .max_i(loop_max_i),
    .outer_lvl_i, .init_lvl_i, .store_lvl_i,
    .cnt_o(idx_o), .busy_o, .load_o(load), .step_o(step), .lvl_o(lvl),
    .init_o, .store_o, .done_o
  );

  for (genvar a = 0; a < N_PTR; a++) begin : g_ptr
    lag_agu #(.AW(PTR_W), .NL(N_LOOP), .LW(LVL_W)) u_agu (
      .clk_i, .rst_ni,
      .load_i(load), .step_i(step), .lvl_i(lvl),
      .base_i(base_i[a*PTR_W +: PTR_W]),
      .tbl_i(step_i[a*N_LOOP*PTR_W +: N_LOOP*PTR_W]),
      .addr_o(addr_o[a*PTR_W +: PTR_W])
    );
  end

  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R7
  AST_STROBE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_o || store_o |-> busy_o); // R8
endmodule

// File: tb/sim_loop_addr_gen.sv
module sim_loop_addr_gen;
  localparam int NL = 5, CW = 16, NA = 3, AW = 32, LW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic start = 1'b0, stall = 1'b0;
  logic [NL-1:0] en;
  logic [CW-1:0] mx [NL];
  logic [LW-1:0] outer, ilvl, slvl;
  logic [AW-1:0] base [NA];
  int            st [NA][NL];
  logic [NL*CW-1:0] max_v;
  logic [NA*AW-1:0] base_v;
  logic [NA*NL*AW-1:0] step_v;
  logic busy, init_s, store_s, done;
  logic [NL*CW-1:0] idx;
  logic [NA*AW-1:0] addr;

  always_comb begin
    for (int k = 0; k < NL; k++) max_v[k*CW +: CW] = mx[k];
    for (int a = 0; a < NA; a++) begin
      base_v[a*AW +: AW] = base[a];
      for (int k = 0; k < NL; k++) step_v[(a*NL+k)*AW +: AW] = AW'(st[a][k]);
    end
  end

  loop_addr_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stall_i(stall),
    .loop_en_i(en), .loop_max_i(max_v), .outer_lvl_i(outer),
    .init_lvl_i(ilvl), .store_lvl_i(slvl), .base_i(base_v), .step_i(step_v),
    .busy_o(busy), .idx_o(idx), .addr_o(addr), .init_o(init_s),
    .store_o(store_s), .done_o(done)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;
  int sz [NL];
  int pr [NL+1];

  task automatic check(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic longint exp_addr(int a, int n);
    longint s = longint'(base[a]);
    for (int k = 0; k < NL; k++)
      s += longint'(st[a][k]) * longint'(n / pr[k] - n / pr[k+1]);
    return longint'(s[31:0]);
  endfunction

  task automatic run(bit stall_on, bit poke);
    int n = 0, cyc = 0, total;
    bit prev_st = 1'b0, prev_pk = 1'b0;
    string tg;
    pr[0] = 1;
    for (int k = 0; k < NL; k++) begin
      sz[k] = (en[k] && k <= int'(outer)) ? int'(mx[k]) + 1 : 1;
      pr[k+1] = pr[k] * sz[k];
    end
    total = pr[NL];
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (n < total && cyc < 5000) begin
      tg = prev_st ? "R6" : (prev_pk ? "R2" : "R5");
      check(n == 0 ? "R2" : "R7", "busy", longint'(busy), 1);
      for (int k = 0; k < NL; k++)
        check(sz[k] == 1 ? "R4" : "R3", $sformatf("idx%0d n=%0d", k, n),
              longint'(idx[k*CW +: CW]), longint'((n / pr[k]) % sz[k]));
      for (int a = 0; a < NA; a++)
        check(a == 0 ? tg : "R10", $sformatf("addr%0d n=%0d", a, n),
              longint'(addr[a*AW +: AW]), exp_addr(a, n));
      check("R8", $sformatf("init n=%0d", n), longint'(init_s),
            longint'((n % pr[ilvl]) == 0));
      check("R9", $sformatf("store n=%0d", n), longint'(store_s),
            longint'(((n + 1) % pr[slvl]) == 0));
      stall = stall_on && (cyc % 3 == 1);
      start = poke && (cyc == 5);
      prev_st = stall;
      prev_pk = start;
      @(negedge clk);
      if (!stall) n++;
      stall = 1'b0;
      start = 1'b0;
      cyc++;
    end
    check("R7", "done pulse", longint'(done), 1);
    check("R7", "busy end", longint'(busy), 0);
    @(negedge clk);
    check("R7", "done single", longint'(done), 0);
  endtask

  initial begin
    en = '1; outer = 3'd4; ilvl = 3'd0; slvl = 3'd0;
    for (int k = 0; k < NL; k++) mx[k] = '0;
    for (int a = 0; a < NA; a++) begin
      base[a] = '0;
      for (int k = 0; k < NL; k++) st[a][k] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "busy", longint'(busy), 0);
    check("R1", "done", longint'(done), 0);
    check("R1", "idx", longint'(idx == '0), 1);
    check("R1", "addr", longint'(addr == '0), 1);
    check("R1", "strobes", longint'({init_s, store_s}), 0);

    // full five-level nest, signed steps, pointer wrap
    mx[0] = 16'd2; mx[1] = 16'd1; mx[2] = 16'd1; mx[3] = 16'd1; mx[4] = 16'd1;
    ilvl = 3'd2; slvl = 3'd1;
    base[0] = 32'h1000; base[1] = 32'h20; base[2] = 32'hFFFF_FFF0;
    st[0] = '{4, -8, 100, 3, -1};
    st[1] = '{1, 2, 3, 4, 5};
    st[2] = '{-4, 16, 0, -256, 7};
    run(1'b0, 1'b0);

    // disabled middle loop, stalls, ignored start
    mx[0] = 16'd3; mx[1] = 16'd5; mx[2] = 16'd2; mx[3] = 16'd9; mx[4] = 16'd9;
    en = 5'b11101; outer = 3'd2; ilvl = 3'd0; slvl = 3'd3;
    run(1'b1, 1'b1);

    // single loop; loops above outer level ignored
    mx[0] = 16'd6; mx[1] = 16'd3; mx[2] = 16'd3; mx[3] = 16'd3; mx[4] = 16'd3;
    en = '1; outer = 3'd0; ilvl = 3'd5; slvl = 3'd5;
    run(1'b1, 1'b0);

    // disabled innermost loop
    mx[0] = 16'd5; mx[1] = 16'd2; mx[2] = 16'd1; mx[3] = 16'd7; mx[4] = 16'd1;
    en = 5'b10110; outer = 3'd4; ilvl = 3'd3; slvl = 3'd2;
    run(1'b1, 1'b0);

    // one-iteration run
    for (int k = 0; k < NL; k++) mx[k] = '0;
    en = '1; outer = 3'd4; ilvl = 3'd1; slvl = 3'd4;
    run(1'b0, 1'b0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule